// File: doc/BRIEF.md
# Q-Channel Subcode Capture and Check Register

This block builds the 96-bit Q subcode word of a disc data stream one bit at a time, one bit per subcode frame, and checks it against its 16-bit cyclic redundancy field. A block-sync strobe marks the start of each word. When a complete word passes the check, its 80 data bits are copied into a holding register and an active-low ready flag is driven low. A word that fails the check is dropped, so the next ready indication arrives one block later.

The held word is presented on a 96-bit output. The 16 positions that carried the check field are filled with live audio peak levels instead, eight bits for each channel. Two peak trackers follow the positive audio samples and are cleared when a read completes. A host opens a read with a start strobe and closes it with a done strobe. A start is accepted while ready is low, or for a short grace window after ready has risen by timeout. A good word that arrives during a read waits in a single pending slot until the read is done.

Top module: `qsub_reg`

## Requirements
- R1: After a good word, q_word[95:16] holds word bits 1 to 80, with bit n at index 96-n (bit 1, the first bit received, at index 95).
- R2: A word of exactly 96 bits whose bits 81 to 96 equal the bitwise inverse of the CRC over bits 1 to 80 (polynomial 0x1021, register initialised to zero, first bit shifted first, check bit 81 as MSB) is loaded and drives rdy_n low.
- R3: A complete word that fails the check leaves the held bits and rdy_n unchanged.
- R4: sc_sync restarts the bit count and discards any partial word; bits after the 96th and before the next sync are ignored.
- R5: q_word[15:8] carries the left peak with its MSB at index 8 and LSB at index 15; q_word[7:0] carries the right peak with its MSB at index 0 and LSB at index 7.
- R6: Each peak is the maximum of sample bits [SMP_W-2:SMP_W-9] over the samples whose sign bit is 0; negative samples do not change it.
- R7: Both peaks read zero after an accepted read is closed by rd_done.
- R8: rd_start is accepted only while rdy_n is low or within GRACE cycles after rdy_n rose by timeout; a rejected start has no effect, and the following rd_done leaves the peaks intact.
- R9: If no read starts, rdy_n returns high READY_HOLD cycles after it went low.
- R10: A good word that completes during a read leaves the held bits unchanged until rd_done, at which point it is loaded and rdy_n is low.
- R11: rd_done on an accepted read with nothing pending ends the read and drives rdy_n high.
- R12: After reset rdy_n is high and q_word is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sc_bit | input | 1 | Q subcode bit |
| sc_bit_vld | input | 1 | Strobe: sc_bit is valid this cycle |
| sc_sync | input | 1 | Subcode block-sync strobe |
| aud_vld | input | 1 | Strobe: audio samples valid |
| aud_left | input | SMP_W | Left sample, two's complement |
| aud_right | input | SMP_W | Right sample, two's complement |
| rd_start | input | 1 | Read-start strobe |
| rd_done | input | 1 | Read-done strobe |
| q_word | output | 96 | Held word with peaks in the check field |
| rdy_n | output | 1 | Active-low ready flag |

## Verification
On every cycle the assertions check that a good word outside a read lowers the ready flag, that the flag only falls after a good word or a closed read, that the held bits stay frozen through a read, that rd_done ends the read and clears the peaks, and that the peaks never fall except at a clear. The read window, the timeout of the flag, the discarding of short blocks and surplus bits, the exact check-field polynomial and the bit placement of the peaks depend on sequences and encoded values, so only the bench's scenarios show them.

// File: rtl/qsub_pkg.sv
package qsub_pkg;
  localparam int Q_LEN    = 96;
  localparam int CRC_W    = 16;
  localparam int PK_W     = 8;
  localparam int PAY_W    = Q_LEN - CRC_W;
  localparam int CNT_W    = $clog2(Q_LEN + 1);
  localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;

  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c, input logic b);
    logic fb;
    logic [CRC_W-1:0] r;
    fb = c[CRC_W-1] ^ b;
    r  = {c[CRC_W-2:0], 1'b0};
    if (fb) r = r ^ CRC_POLY;
    return r;
  endfunction
endpackage

// File: rtl/qsub_accum.sv
module qsub_accum
  import qsub_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_i,
  input  logic             bit_vld_i,
  input  logic             sync_i,
  output logic [PAY_W-1:0] pay_o,
  output logic             good_o
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(Q_LEN);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(Q_LEN - 1);
  localparam logic [CNT_W-1:0] CNT_PAY  = CNT_W'(PAY_W);

  logic [Q_LEN-1:0] sh_q, sh_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CRC_W-1:0] crc_q, crc_d;
  logic             done_q, done_d;
  logic             sh_en;

  assign sh_en = bit_vld_i && !sync_i && (cnt_q < CNT_FULL);

  always_comb begin
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    crc_d  = crc_q;
    done_d = 1'b0;
    if (sync_i) begin
      cnt_d = '0;
      crc_d = '0;
    end else if (sh_en) begin
      sh_d  = {sh_q[Q_LEN-2:0], bit_i};
      cnt_d = cnt_q + 1'b1;
      if (cnt_q < CNT_PAY) crc_d = crc_step(crc_q, bit_i);
      if (cnt_q == CNT_LAST) done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      crc_q  <= '0;
      done_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      crc_q  <= crc_d;
      done_q <= done_d;
    end
  end

  assign pay_o  = sh_q[Q_LEN-1:CRC_W];
  assign good_o = done_q && (sh_q[CRC_W-1:0] == ~crc_q);
endmodule

// File: rtl/qsub_peak.sv
module qsub_peak
  import qsub_pkg::*;
#(
  parameter int SMP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vld_i,
  input  logic [SMP_W-1:0] smp_i,
  input  logic             clr_i,
  output logic [PK_W-1:0]  peak_o
);
  logic [PK_W-1:0] pk_q, pk_d, cand, base;

  assign cand = smp_i[SMP_W-1] ? '0 : smp_i[SMP_W-2 -: PK_W];
  assign base = clr_i ? '0 : pk_q;

  always_comb begin
    pk_d = base;
    if (vld_i && (cand > base)) pk_d = cand;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pk_q <= '0;
    else        pk_q <= pk_d;
  end

  assign peak_o = pk_q;
endmodule

// File: rtl/qsub_ctrl.sv
module qsub_ctrl
  import qsub_pkg::*;
#(
  parameter int READY_HOLD = 400,
  parameter int GRACE      = 60
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             good_i,
  input  logic [PAY_W-1:0] pay_i,
  input  logic             rd_start_i,
  input  logic             rd_done_i,
  output logic [PAY_W-1:0] hold_o,
  output logic             rdy_n_o,
  output logic             reading_o,
  output logic             clr_o
);
  localparam int TMR_W = $clog2(READY_HOLD);
  localparam int GR_W  = $clog2(GRACE + 1);
  localparam logic [TMR_W-1:0] TMR_END = TMR_W'(READY_HOLD - 1);
  localparam logic [GR_W-1:0]  GR_INIT = GR_W'(GRACE);

  logic [PAY_W-1:0] hold_q, hold_d, pend_q, pend_d;
  logic             hvld_q, hvld_d, pvld_q, pvld_d;
  logic             rd_q, rd_d, rdy_n_q, rdy_n_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic [GR_W-1:0]  gr_q, gr_d;
  logic             done, load_now, to_pend, start_ok;

  assign done     = rd_q && rd_done_i;
  assign load_now = good_i && (!rd_q || rd_done_i);
  assign to_pend  = good_i && rd_q && !rd_done_i;
  assign start_ok = rd_start_i && !rd_q && hvld_q && (!rdy_n_q || (gr_q != '0));

  always_comb begin
    hold_d  = hold_q;
    hvld_d  = hvld_q;
    pend_d  = pend_q;
    pvld_d  = pvld_q;
    rd_d    = rd_q;
    rdy_n_d = rdy_n_q;
    tmr_d   = tmr_q;
    gr_d    = gr_q;
    if (to_pend) begin
      pend_d = pay_i;
      pvld_d = 1'b1;
    end
    if (done) begin
      rd_d   = 1'b0;
      pvld_d = 1'b0;
    end
    if (start_ok) rd_d = 1'b1;
    if (load_now) begin
      hold_d = pay_i;
      hvld_d = 1'b1;
    end else if (done && pvld_q) begin
      hold_d = pend_q;
    end
    if (load_now || (done && pvld_q)) begin
      rdy_n_d = 1'b0;
      tmr_d   = '0;
      gr_d    = '0;
    end else if (done) begin
      rdy_n_d = 1'b1;
      gr_d    = '0;
    end else if (!rd_q && !rdy_n_q) begin
      if (tmr_q == TMR_END) begin
        rdy_n_d = 1'b1;
        tmr_d   = '0;
        gr_d    = GR_INIT;
      end else begin
        tmr_d = tmr_q + 1'b1;
      end
    end else if (!rd_q && (gr_q != '0)) begin
      gr_d = gr_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      hvld_q  <= 1'b0;
      pend_q  <= '0;
      pvld_q  <= 1'b0;
      rd_q    <= 1'b0;
      rdy_n_q <= 1'b1;
      tmr_q   <= '0;
      gr_q    <= '0;
    end else begin
      hold_q  <= hold_d;
      hvld_q  <= hvld_d;
      pend_q  <= pend_d;
      pvld_q  <= pvld_d;
      rd_q    <= rd_d;
      rdy_n_q <= rdy_n_d;
      tmr_q   <= tmr_d;
      gr_q    <= gr_d;
    end
  end

  assign hold_o    = hold_q;
  assign rdy_n_o   = rdy_n_q;
  assign reading_o = rd_q;
  assign clr_o     = done;
endmodule

// File: rtl/qsub_reg.sv
module qsub_reg
  import qsub_pkg::*;
#(
  parameter int SMP_W      = 16,
  parameter int READY_HOLD = 400,
  parameter int GRACE      = 60
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sc_bit,
  input  logic             sc_bit_vld,
  input  logic             sc_sync,
  input  logic             aud_vld,
  input  logic [SMP_W-1:0] aud_left,
  input  logic [SMP_W-1:0] aud_right,
  input  logic             rd_start,
  input  logic             rd_done,
  output logic [Q_LEN-1:0] q_word,
  output logic             rdy_n
);
  logic [PAY_W-1:0] acc_pay, hold;
  logic             acc_good, reading, pk_clr;
  logic [SMP_W-1:0] smp [2];
  logic [PK_W-1:0]  pk  [2];
  logic [PK_W-1:0]  pk_l, pk_r;

  qsub_accum u_acc (
    .clk(clk), .rst_n(rst_n), .bit_i(sc_bit), .bit_vld_i(sc_bit_vld),
    .sync_i(sc_sync), .pay_o(acc_pay), .good_o(acc_good)
  );

  qsub_ctrl #(.READY_HOLD(READY_HOLD), .GRACE(GRACE)) u_ctl (
    .clk(clk), .rst_n(rst_n), .good_i(acc_good), .pay_i(acc_pay),
    .rd_start_i(rd_start), .rd_done_i(rd_done), .hold_o(hold),
    .rdy_n_o(rdy_n), .reading_o(reading), .clr_o(pk_clr)
  );

  assign smp[0] = aud_left;
  assign smp[1] = aud_right;

  for (genvar ch = 0; ch < 2; ch++) begin : g_pk
    qsub_peak #(.SMP_W(SMP_W)) u_pk (
      .clk(clk), .rst_n(rst_n), .vld_i(aud_vld), .smp_i(smp[ch]),
      .clr_i(pk_clr), .peak_o(pk[ch])
    );
  end

  assign pk_l = pk[0];
  assign pk_r = pk[1];
  assign q_word[Q_LEN-1:CRC_W] = hold;

  for (genvar i = 0; i < PK_W; i++) begin : g_rev
    assign q_word[CRC_W-1-i] = pk_l[i];
    assign q_word[PK_W-1-i]  = pk_r[i];
  end
endmodule

// File: rtl/qsub_reg_chk.sv
module qsub_reg_chk
  import qsub_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             rdy_n,
  input logic [Q_LEN-1:0] q_word,
  input logic             rd_done,
  input logic             reading,
  input logic             acc_good,
  input logic             aud_vld,
  input logic [PK_W-1:0]  pk_l,
  input logic [PK_W-1:0]  pk_r
);
  a_r2_good_sets_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_good && !reading) |=> !rdy_n);

  a_r3_ready_falls_on_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy_n) |-> $past(acc_good || (reading && rd_done)));

  a_r10_hold_frozen_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    (reading && !rd_done) |=> $stable(q_word[Q_LEN-1:CRC_W]));

  a_r11_done_ends_read: assert property (@(posedge clk) disable iff (!rst_n)
    (reading && rd_done) |=> !reading);

  a_r7_peaks_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (reading && rd_done && !aud_vld) |=> (q_word[CRC_W-1:0] == '0));

  a_r6_peak_no_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !(reading && rd_done) |=> ((pk_l >= $past(pk_l)) && (pk_r >= $past(pk_r))));
endmodule

bind qsub_reg qsub_reg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rdy_n(rdy_n), .q_word(q_word), .rd_done(rd_done),
  .reading(reading), .acc_good(acc_good), .aud_vld(aud_vld), .pk_l(pk_l), .pk_r(pk_r)
);

// File: tb/sim_qsub_reg.sv
`timescale 1ns/1ps
module sim_qsub_reg;
  localparam int SMP_W = 16;
  localparam int HOLD  = 400;
  localparam int GR    = 60;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sc_bit = 1'b0, sc_bit_vld = 1'b0, sc_sync = 1'b0;
  logic aud_vld = 1'b0;
  logic [SMP_W-1:0] aud_left = '0, aud_right = '0;
  logic rd_start = 1'b0, rd_done = 1'b0;
  logic [95:0] q_word;
  logic rdy_n;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  qsub_reg #(.SMP_W(SMP_W), .READY_HOLD(HOLD), .GRACE(GR)) u0 (
    .clk(clk), .rst_n(rst_n), .sc_bit(sc_bit), .sc_bit_vld(sc_bit_vld),
    .sc_sync(sc_sync), .aud_vld(aud_vld), .aud_left(aud_left),
    .aud_right(aud_right), .rd_start(rd_start), .rd_done(rd_done),
    .q_word(q_word), .rdy_n(rdy_n)
  );

  function automatic logic [15:0] ref_crc(input logic [79:0] p);
    logic [15:0] c = '0;
    for (int i = 79; i >= 0; i--) begin
      logic fb;
      fb = c[15] ^ p[i];
      c  = {c[14:0], 1'b0};
      if (fb) c = c ^ 16'h1021;
    end
    return c;
  endfunction

  function automatic logic [95:0] mk_word(input logic [79:0] p);
    return {p, ~ref_crc(p)};
  endfunction

  function automatic logic [7:0] rev8(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7-i];
    return r;
  endfunction

  function automatic logic [7:0] pk_of(input logic [SMP_W-1:0] s);
    return s[SMP_W-1] ? 8'h00 : s[SMP_W-2 -: 8];
  endfunction

  task automatic check(input string req, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_sync();
    @(negedge clk); sc_sync = 1'b1;
    @(negedge clk); sc_sync = 1'b0;
  endtask

  task automatic send_bits(input logic [95:0] w, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sc_bit = w[95-i]; sc_bit_vld = 1'b1;
      @(negedge clk); sc_bit_vld = 1'b0;
    end
    tick(3);
  endtask

  task automatic send_word(input logic [95:0] w);
    pulse_sync();
    send_bits(w, 96);
  endtask

  task automatic audio(input logic [SMP_W-1:0] l, input logic [SMP_W-1:0] r);
    @(negedge clk); aud_left = l; aud_right = r; aud_vld = 1'b1;
    @(negedge clk); aud_vld = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); rd_start = 1'b1;
    @(negedge clk); rd_start = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk); rd_done = 1'b1;
    @(negedge clk); rd_done = 1'b0;
    tick(1);
  endtask

  logic [79:0] pa, pb, pc, pd, pe, pf;

  task automatic t_reset();
    check("R12 rdy_n", {95'd0, rdy_n}, 96'd1);
    check("R12 q_word", q_word, 96'd0);
  endtask

  task automatic t_good_word();
    send_word(mk_word(pa));
    check("R2 rdy_n low", {95'd0, rdy_n}, 96'd0);
    check("R1 payload", {16'd0, q_word[95:16]}, {16'd0, pa});
    check("R5 zero peaks", {80'd0, q_word[15:0]}, 96'd0);
  endtask

  task automatic t_peaks();
    logic [7:0] el, er;
    audio(16'h1234, 16'h0100);
    audio(16'h8000, 16'h7FFF);
    audio(16'h2000, 16'h0300);
    audio(16'h0500, 16'hFFFF);
    tick(1);
    el = pk_of(16'h2000);
    er = pk_of(16'h7FFF);
    check("R6 left peak", {88'd0, q_word[15:8]}, {88'd0, rev8(el)});
    check("R5 right peak order", {88'd0, q_word[7:0]}, {88'd0, rev8(er)});
  endtask

  task automatic t_read();
    pulse_start();
    pulse_done();
    check("R11 rdy_n high", {95'd0, rdy_n}, 96'd1);
    check("R7 peaks cleared", {80'd0, q_word[15:0]}, 96'd0);
  endtask

  task automatic t_bad_crc();
    logic [95:0] w;
    w = mk_word(pb);
    w[3] = ~w[3];
    send_word(w);
    check("R3 rdy_n stays", {95'd0, rdy_n}, 96'd1);
    check("R3 hold kept", {16'd0, q_word[95:16]}, {16'd0, pa});
  endtask

  task automatic t_short_block();
    pulse_sync();
    send_bits(mk_word(pb), 50);
    send_word(mk_word(pc));
    check("R4 short discarded", {16'd0, q_word[95:16]}, {16'd0, pc});
    send_bits(mk_word(pb), 20);
    check("R4 extra bits ignored", {16'd0, q_word[95:16]}, {16'd0, pc});
    pulse_start();
    pulse_done();
  endtask

  task automatic t_timeout_grace();
    send_word(mk_word(pd));
    check("R2 rdy_n low", {95'd0, rdy_n}, 96'd0);
    tick(HOLD + 5);
    check("R9 timeout", {95'd0, rdy_n}, 96'd1);
    audio(16'h4000, 16'h1000);
    pulse_start();
    pulse_done();
    check("R8 grace read accepted", {80'd0, q_word[15:0]}, 96'd0);
  endtask

  task automatic t_window_miss();
    send_word(mk_word(pe));
    tick(HOLD + GR + 10);
    audio(16'h3000, 16'h0800);
    pulse_start();
    pulse_done();
    check("R8 late start ignored",
          {80'd0, q_word[15:0]}, {80'd0, rev8(pk_of(16'h3000)), rev8(pk_of(16'h0800))});
    check("R8 rdy_n high", {95'd0, rdy_n}, 96'd1);
    audio(16'h0000, 16'h0000);
  endtask

  task automatic t_pending();
    send_word(mk_word(pa));
    pulse_start();
    send_word(mk_word(pf));
    check("R10 hold during read", {16'd0, q_word[95:16]}, {16'd0, pa});
    pulse_done();
    check("R10 pending loaded", {16'd0, q_word[95:16]}, {16'd0, pf});
    check("R10 rdy_n low", {95'd0, rdy_n}, 96'd0);
    pulse_start();
    pulse_done();
    check("R11 read closed", {95'd0, rdy_n}, 96'd1);
  endtask

  initial begin
    pa = 80'hA1B2_C3D4_E5F6_0718_293A;
    pb = 80'h1357_9BDF_0246_8ACE_F00F;
    pc = 80'hFEDC_BA98_7654_3210_5A5A;
    pd = 80'h0F0F_F0F0_1234_4321_C0DE;
    pe = 80'h8000_0000_0000_0000_0001;
    pf = 80'h3C3C_9696_ABAB_CDCD_EF01;
    tick(3);
    t_reset();
    rst_n = 1'b1;
    tick(2);
    t_reset();
    t_good_word();
    t_peaks();
    t_read();
    t_bad_crc();
    t_short_block();
    t_timeout_grace();
    t_window_miss();
    t_pending();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule